// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Parked Default Connection

This block sits on the slave side of a multi-master crossbar and decides which master owns the slave. Each master drives a request line. The slave port pulses a transfer-done signal when an access ends. The arbiter holds a registered one-hot grant and raises a connection-valid flag while any master is connected.

Two settings control the block. Both are read only when the arbiter makes a decision. The parking setting chooses where the slave rests when nobody is requesting: disconnected, on the last owner, or on a programmed default master. A master that finds itself already parked gets its grant with no wait. Any other master pays one arbitration cycle. The selection setting chooses round-robin rotation or fixed priority. In fixed-priority mode each master has a 2-bit priority field.

Top module: `slv_arbiter`

## Requirements
- R1: `grant` is one-hot or all zero, `conn_valid` is high exactly when `grant` is nonzero, and reset (asynchronous, active low) clears `grant`.
- R2: While the connected master keeps its request high and `xfer_done` is low, `grant` does not change.
- R3: A master already parked on the slave sees its `grant` bit high in the same cycle it raises its request.
- R4: When the slave is idle and a master that is not connected requests, its grant appears after exactly one clock edge.
- R5: With `cfg_park` = 2'b00 (or 2'b11), the slave disconnects at an arbitration point where no master is requesting.
- R6: With `cfg_park` = 2'b01, the slave stays connected to the last owner at an arbitration point where no master is requesting.
- R7: With `cfg_park` = 2'b10, the slave connects to master `cfg_fixed_idx` at an arbitration point where no master is requesting.
- R8: With `cfg_sched` = 0 (round-robin), the search starts at the master just after the last master granted from a request and wraps around. That index is updated only when a grant is given to a requester, in either scheme, and is N-1 after reset.
- R9: With `cfg_sched` = 1 (fixed priority), the requester with the largest priority value wins. Master i's priority is `cfg_prio[2i+1:2i]`.
- R10: Among fixed-priority requesters with equal priority, the highest master index wins.
- R11: An arbitration point is a cycle with `xfer_done` high, or a cycle in which the connected master (if any) is not requesting. Configuration changes affect `grant` only at arbitration points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | Request line per master |
| xfer_done | input | 1 | Slave pulse marking the end of the current access |
| cfg_park | input | 2 | Parking mode: 00 none, 01 last owner, 10 fixed master |
| cfg_fixed_idx | input | IDXW | Default master index for fixed parking |
| cfg_sched | input | 1 | 0 round-robin, 1 fixed priority |
| cfg_prio | input | N*PW | Priority field per master |
| grant | output | N | Registered one-hot grant |
| conn_valid | output | 1 | High while a master is connected |

## Verification
The bench targets four failure modes:
- Zero-latency parking: a parked master raises its request and the grant must already be high in that cycle. A design that re-arbitrates there would show a one-cycle gap.
- Mid-transfer changes: requests, scheduling mode and default index are changed while an access is running. An arbiter that decides every cycle would drop its owner.
- Fixed-priority ties: requesters with equal priority fields must resolve toward the highest index. A low-index bias would pick the wrong master.
- Round-robin rotation: the pointer is carried across a stretch of fixed-priority grants and then wraps past the top index. A pointer that is not updated, or that is updated by parking, would repeat a master or skip one.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;
  typedef enum logic [1:0] {
    PARK_NONE  = 2'b00,
    PARK_LAST  = 2'b01,
    PARK_FIXED = 2'b10,
    PARK_RSVD  = 2'b11
  } park_e;

  typedef enum logic {
    SCHED_RR   = 1'b0,
    SCHED_PRIO = 1'b1
  } sched_e;
endpackage

// File: rtl/slv_rst_sync.sv
module slv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/slv_rr_pick.sv
module slv_rr_pick #(
  parameter int N    = 4,
  parameter int IDXW = 2
) (
  input  logic [N-1:0]    req,
  input  logic [IDXW-1:0] last_idx,
  output logic            found,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    int j;
    found = 1'b0;
    idx   = '0;
    j     = 0;
    for (int k = 1; k <= N; k++) begin
      j = (int'(last_idx) + k) % N;
      if (!found && req[j]) begin
        found = 1'b1;
        idx   = IDXW'(j);
      end
    end
  end
endmodule

// File: rtl/slv_prio_pick.sv
module slv_prio_pick #(
  parameter int N    = 4,
  parameter int PW   = 2,
  parameter int IDXW = 2
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    logic [PW-1:0] best;
    found = 1'b0;
    idx   = '0;
    best  = '0;
    // ascending scan with >= lets the higher index take a tie
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || prio[i*PW +: PW] >= best)) begin
        found = 1'b1;
        best  = prio[i*PW +: PW];
        idx   = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/slv_arbiter.sv
module slv_arbiter #(
  parameter int N    = 4,
  parameter int PW   = 2,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic            xfer_done,
  input  logic [1:0]      cfg_park,
  input  logic [IDXW-1:0] cfg_fixed_idx,
  input  logic            cfg_sched,
  input  logic [N*PW-1:0] cfg_prio,
  output logic [N-1:0]    grant,
  output logic            conn_valid
);
  import slv_arb_pkg::*;

  localparam logic [IDXW-1:0] PTR_RST = IDXW'(N - 1);

  logic            rst_sync_n;
  logic [N-1:0]    grant_q, grant_d;
  logic [IDXW-1:0] ptr_q, ptr_d;
  logic [IDXW-1:0] owner_idx;
  logic            owner_busy;
  logic            arb_pt;
  logic            any_req;
  logic            rr_found, pr_found;
  logic [IDXW-1:0] rr_idx, pr_idx, win_idx;
  logic            fixed_ok;
  park_e           park_mode;
  sched_e          sched_mode;

  slv_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  slv_rr_pick #(.N(N), .IDXW(IDXW)) i_rr_pick (
    .req      (req),
    .last_idx (ptr_q),
    .found    (rr_found),
    .idx      (rr_idx)
  );

  slv_prio_pick #(.N(N), .PW(PW), .IDXW(IDXW)) i_prio_pick (
    .req   (req),
    .prio  (cfg_prio),
    .found (pr_found),
    .idx   (pr_idx)
  );

  assign park_mode  = park_e'(cfg_park);
  assign sched_mode = sched_e'(cfg_sched);

  always_comb begin
    owner_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_q[i]) owner_idx = IDXW'(i);
    end
  end

  assign conn_valid = |grant_q;
  assign owner_busy = conn_valid && req[owner_idx];
  assign arb_pt     = xfer_done || !owner_busy;
  assign any_req    = |req;
  assign win_idx    = (sched_mode == SCHED_PRIO) ? pr_idx : rr_idx;
  assign fixed_ok   = int'(cfg_fixed_idx) < N;

  always_comb begin
    grant_d = grant_q;
    ptr_d   = ptr_q;
    if (any_req && (rr_found || pr_found)) begin
      grant_d          = '0;
      grant_d[win_idx] = 1'b1;
      ptr_d            = win_idx;
    end else begin
      unique case (park_mode)
        PARK_LAST:  grant_d = grant_q;
        PARK_FIXED: begin
          grant_d = '0;
          if (fixed_ok) grant_d[cfg_fixed_idx] = 1'b1;
        end
        default:    grant_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      grant_q <= '0;
      ptr_q   <= PTR_RST;
    end else if (arb_pt) begin
      grant_q <= grant_d;
      ptr_q   <= ptr_d;
    end
  end

  assign grant = grant_q;

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant_q));

  p_mid_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(req & grant_q) && !xfer_done) |=> $stable(grant_q));

  p_req_served_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (any_req && arb_pt) |=> |(grant_q & $past(req)));

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cfg_park == 2'b00) && arb_pt && !any_req) |=> (grant_q == '0));

  p_keep_last_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cfg_park == 2'b01) && arb_pt && !any_req) |=> $stable(grant_q));

  p_park_fixed_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cfg_park == 2'b10) && arb_pt && !any_req && fixed_ok)
      |=> (grant_q == (N'(1) << $past(cfg_fixed_idx))));
endmodule

// File: tb/test_slv_arbiter.sv
module test_slv_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int NV = 25;
  localparam int WDOG = 10000;

  logic         clk;
  logic         rst_n;
  logic [3:0]   req;
  logic         xfer_done;
  logic [1:0]   cfg_park;
  logic [1:0]   cfg_fixed_idx;
  logic         cfg_sched;
  logic [7:0]   cfg_prio;
  logic [3:0]   grant;
  logic         conn_valid;

  int n_chk;
  int n_fail;
  int cyc;

  // {tag5, req4, done1, park2, sched1, prio8, fidx2, expected_grant4}
  localparam logic [26:0] VEC [NV] = '{
    {5'd5,  4'b0000, 1'b0, 2'b00, 1'b0, 8'h00, 2'd0, 4'b0000}, // R5 idle, none
    {5'd8,  4'b0010, 1'b0, 2'b00, 1'b0, 8'h00, 2'd0, 4'b0010}, // R8 first rr grant
    {5'd2,  4'b0010, 1'b0, 2'b00, 1'b0, 8'h00, 2'd0, 4'b0010}, // R2 hold
    {5'd8,  4'b0110, 1'b1, 2'b00, 1'b0, 8'h00, 2'd0, 4'b0100}, // R8 rotate
    {5'd2,  4'b0110, 1'b0, 2'b00, 1'b0, 8'h00, 2'd0, 4'b0100}, // R2 hold
    {5'd5,  4'b0000, 1'b1, 2'b00, 1'b0, 8'h00, 2'd0, 4'b0000}, // R5 release
    {5'd8,  4'b1000, 1'b0, 2'b01, 1'b0, 8'h00, 2'd0, 4'b1000}, // R8
    {5'd6,  4'b0000, 1'b1, 2'b01, 1'b0, 8'h00, 2'd0, 4'b1000}, // R6 park last
    {5'd6,  4'b0000, 1'b0, 2'b01, 1'b0, 8'h00, 2'd0, 4'b1000}, // R6
    {5'd3,  4'b1000, 1'b0, 2'b01, 1'b0, 8'h00, 2'd0, 4'b1000}, // R3 parked owner
    {5'd6,  4'b0000, 1'b1, 2'b01, 1'b0, 8'h00, 2'd0, 4'b1000}, // R6
    {5'd4,  4'b0001, 1'b0, 2'b01, 1'b0, 8'h00, 2'd0, 4'b0001}, // R4 new master
    {5'd7,  4'b0000, 1'b1, 2'b10, 1'b0, 8'h00, 2'd2, 4'b0100}, // R7 fixed park
    {5'd3,  4'b0100, 1'b0, 2'b10, 1'b0, 8'h00, 2'd2, 4'b0100}, // R3
    {5'd7,  4'b0000, 1'b1, 2'b10, 1'b0, 8'h00, 2'd2, 4'b0100}, // R7
    {5'd11, 4'b0000, 1'b0, 2'b10, 1'b0, 8'h00, 2'd1, 4'b0010}, // R11 idle applies cfg
    {5'd11, 4'b0111, 1'b0, 2'b10, 1'b1, 8'h27, 2'd1, 4'b0010}, // R11 busy ignores cfg
    {5'd9,  4'b0111, 1'b1, 2'b10, 1'b1, 8'h27, 2'd1, 4'b0001}, // R9 prio 3 wins
    {5'd9,  4'b1110, 1'b1, 2'b10, 1'b1, 8'h27, 2'd1, 4'b0100}, // R9 prio 2 wins
    {5'd10, 4'b1011, 1'b1, 2'b10, 1'b1, 8'h55, 2'd1, 4'b1000}, // R10 tie high idx
    {5'd10, 4'b0011, 1'b1, 2'b10, 1'b1, 8'h55, 2'd1, 4'b0010}, // R10
    {5'd8,  4'b1111, 1'b1, 2'b00, 1'b0, 8'h55, 2'd0, 4'b0100}, // R8 ptr after prio
    {5'd8,  4'b1111, 1'b1, 2'b00, 1'b0, 8'h55, 2'd0, 4'b1000}, // R8
    {5'd8,  4'b1111, 1'b1, 2'b00, 1'b0, 8'h55, 2'd0, 4'b0001}, // R8 wrap
    {5'd5,  4'b0000, 1'b1, 2'b00, 1'b0, 8'h55, 2'd0, 4'b0000}  // R5
  };

  slv_arbiter #(.N(N), .PW(2)) i_slv_arbiter (
    .clk           (clk),
    .rst_n         (rst_n),
    .req           (req),
    .xfer_done     (xfer_done),
    .cfg_park      (cfg_park),
    .cfg_fixed_idx (cfg_fixed_idx),
    .cfg_sched     (cfg_sched),
    .cfg_prio      (cfg_prio),
    .grant         (grant),
    .conn_valid    (conn_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0; req = '0; xfer_done = 1'b0;
    cfg_park = 2'b00; cfg_fixed_idx = '0; cfg_sched = 1'b0; cfg_prio = '0;
    repeat (3) @(negedge clk);
    check("R1 reset grant", grant, 4'b0000);
    check("R1 reset conn_valid", {3'b0, conn_valid}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      req           = VEC[v][21:18];
      xfer_done     = VEC[v][17];
      cfg_park      = VEC[v][16:15];
      cfg_sched     = VEC[v][14];
      cfg_prio      = VEC[v][13:6];
      cfg_fixed_idx = VEC[v][5:4];
      step();
      check($sformatf("R%0d vec %0d grant", VEC[v][26:22], v), grant, VEC[v][3:0]);
      check($sformatf("R1 vec %0d conn_valid", v), {3'b0, conn_valid}, {3'b0, |VEC[v][3:0]});
    end

    // R3 / R4: parked master sees grant at once, another waits one edge
    req = '0; xfer_done = 1'b0; cfg_park = 2'b10; cfg_fixed_idx = 2'd3; cfg_sched = 1'b0;
    step();
    check("R7 park on 3", grant, 4'b1000);
    req = 4'b1000;
    #1;
    check("R3 same-cycle grant", grant, 4'b1000);
    step();
    check("R2 owner held", grant, 4'b1000);
    req = 4'b0001;
    #1;
    check("R4 not yet granted", grant, 4'b1000);
    step();
    check("R4 granted after one edge", grant, 4'b0001);
    // R11: config changes during a running access have no effect
    cfg_sched = 1'b1; cfg_prio = 8'hC0; cfg_fixed_idx = 2'd2; req = 4'b1001;
    step();
    check("R11 mid-transfer cfg ignored", grant, 4'b0001);
    xfer_done = 1'b1;
    step();
    check("R9 prio applied at done", grant, 4'b1000);
    xfer_done = 1'b0;
    // R1: asynchronous reset clears the grant at once
    rst_n = 1'b0;
    #1;
    check("R1 async reset grant", grant, 4'b0000);
    check("R1 async reset conn_valid", {3'b0, conn_valid}, 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule